// File: doc/BRIEF.md
# Rotating XOR String Hash Unit

This unit folds a stream of text characters into a short hash value. A dictionary-lookup pipeline uses it to pick a table bucket for a word. Characters arrive two at a time, packed into one 16-bit word. The first character sits in bits 15:8 and the second in bits 7:0.

Each accepted pair is widened to the hash width by adding zeros on the upper side. It is then XORed with the current hash state and with a fixed per-instance key. The result is rotated left by a fixed number of positions to give the next state.

A clear strobe starts a new word from an all-zero state. The step that carries the end-of-word marker closes the word. One cycle later a done pulse appears, and the hash stays frozen until the next clear.

Words of odd length end with a half-filled pair. For that pair the unit substitutes the space code for the unused low byte. The key, hash width and rotate distance are parameters, so several units can hash the same text with different functions side by side.

Top module: `rxh_unit`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it, `hash_o` is all zeros and `done_o` is low.
- R2: A clear (`clr_i` high) sets `hash_o` to zero and `done_o` low on the next edge. A step presented in the same cycle as a clear is discarded.
- R3: An accepted step forms next = rotl(state XOR zext(pair_i) XOR HASH_KEY, ROT). `pair_i[15:8]` is the first character, `pair_i[7:0]` the second, and the pair is zero-extended on the upper side.
- R4: Rotation is to the left by ROT (default 7) positions, with the top ROT bits wrapping into the lowest positions. With the default key 22'h2A5C31, one step with a zero pair from a cleared state gives 22'h2E18D4.
- R5: In a cycle with `pair_vld_i` low and no clear, `hash_o` keeps its value.
- R6: When `single_i` is high with a valid step, the low byte of `pair_i` is ignored and the space code 8'h20 is used in its place.
- R7: `done_o` is high for exactly one cycle: the cycle after the edge that accepts a step with `last_i` high.
- R8: After the end-of-word step, further valid steps are ignored. `hash_o` holds steady until the next clear or reset.
- R9: Units with different HASH_KEY, HASH_W and ROT values, fed the same text, each follow the R3 formula with their own parameters.
- R10: A reset in the middle of a word drops the partial hash. The next word then starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, acts like a clear |
| clr_i | input | 1 | Clear strobe: zero the hash and open a new word |
| pair_vld_i | input | 1 | `pair_i` carries a character pair this cycle |
| pair_i | input | 16 | Character pair, first character in bits 15:8 |
| single_i | input | 1 | Only the high byte is a real character; pad the low byte with a space |
| last_i | input | 1 | This pair ends the word |
| hash_o | output | HASH_W (22) | Current hash state |
| done_o | output | 1 | One-cycle pulse after the end-of-word step |

## Verification
Every step feeds back through the state register, so one wrong bit in the key, the padding or the rotate changes `hash_o` on the very next edge. The error then spreads to other bit positions with each later step. Comparing `hash_o` after every word, and after single steps from a cleared state, therefore exposes a fault within one cycle of the step that caused it.

A wrong word-state flag shows up differently. It appears as a missing or doubled `done_o` pulse, or as `hash_o` moving after the end of the word. Both are visible in the cycle following the offending step.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  localparam int CHAR_W = 8;
  localparam int PAIR_W = 2 * CHAR_W;
  localparam logic [CHAR_W-1:0] SPACE_CODE = 8'h20;

  typedef enum logic {
    W_OPEN   = 1'b0,
    W_SEALED = 1'b1
  } word_st_t;

  // Replace the second character by a space when only one is present.
  function automatic logic [PAIR_W-1:0] pad_pair(input logic [PAIR_W-1:0] p,
                                                 input logic single);
    pad_pair = single ? {p[PAIR_W-1:CHAR_W], SPACE_CODE} : p;
  endfunction
endpackage

// File: rtl/rxh_pad.sv
module rxh_pad
  import rxh_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_i,
  input  logic              single_i,
  output logic [PAIR_W-1:0] pair_o
);
  always_comb pair_o = pad_pair(pair_i, single_i);
endmodule

// File: rtl/rxh_mix.sv
module rxh_mix #(
  parameter int                HASH_W   = 22,
  parameter int                PAIR_W   = 16,
  parameter int                ROT      = 7,
  parameter logic [HASH_W-1:0] HASH_KEY = '0
) (
  input  logic [HASH_W-1:0] state_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [HASH_W-1:0] mix_o,
  output logic [HASH_W-1:0] next_o
);
  localparam int RS = ROT % HASH_W;
  localparam int EXT_W = HASH_W - PAIR_W;

  function automatic logic [HASH_W-1:0] rotl(input logic [HASH_W-1:0] x);
    logic [2*HASH_W-1:0] dbl;
    dbl  = {x, x};
    rotl = dbl[2*HASH_W-1-RS -: HASH_W];
  endfunction

  function automatic logic [HASH_W-1:0] widen(input logic [PAIR_W-1:0] p);
    widen = {{EXT_W{1'b0}}, p};
  endfunction

  always_comb begin
    mix_o  = state_i ^ widen(pair_i) ^ HASH_KEY;
    next_o = rotl(mix_o);
  end
endmodule

// File: rtl/rxh_ctrl.sv
module rxh_ctrl
  import rxh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic pair_vld_i,
  input  logic last_i,
  output logic step_fire_o,
  output logic sealed_o,
  output logic done_o
);
  word_st_t st_q;

  always_comb step_fire_o = pair_vld_i && !clr_i && (st_q == W_OPEN);
  always_comb sealed_o = (st_q == W_SEALED);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      st_q   <= W_OPEN;
      done_o <= 1'b0;
    end else begin
      done_o <= step_fire_o && last_i;
      if (step_fire_o && last_i) st_q <= W_SEALED;
    end
  end
endmodule

// File: rtl/rxh_state.sv
module rxh_state #(
  parameter int HASH_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [HASH_W-1:0] next_i,
  output logic [HASH_W-1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) state_o <= '0;
    else if (load_i)  state_o <= next_i;
  end
endmodule

// File: rtl/rxh_unit.sv
module rxh_unit
  import rxh_pkg::*;
#(
  parameter int                HASH_W   = 22,
  parameter int                ROT      = 7,
  parameter logic [HASH_W-1:0] HASH_KEY = 22'h2A5C31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              pair_vld_i,
  input  logic [15:0]       pair_i,
  input  logic              single_i,
  input  logic              last_i,
  output logic [HASH_W-1:0] hash_o,
  output logic              done_o
);
  logic [PAIR_W-1:0] padded_w;
  logic [HASH_W-1:0] mix_w;
  logic [HASH_W-1:0] next_w;
  logic              step_fire;
  logic              sealed;
  logic              word_end;

  always_comb word_end = step_fire && last_i;

  rxh_pad u_pad (
    .pair_i   (pair_i),
    .single_i (single_i),
    .pair_o   (padded_w)
  );

  rxh_mix #(
    .HASH_W   (HASH_W),
    .PAIR_W   (PAIR_W),
    .ROT      (ROT),
    .HASH_KEY (HASH_KEY)
  ) u_mix (
    .state_i (hash_o),
    .pair_i  (padded_w),
    .mix_o   (mix_w),
    .next_o  (next_w)
  );

  rxh_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr_i),
    .pair_vld_i  (pair_vld_i),
    .last_i      (last_i),
    .step_fire_o (step_fire),
    .sealed_o    (sealed),
    .done_o      (done_o)
  );

  rxh_state #(.HASH_W(HASH_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .load_i  (step_fire),
    .next_i  (next_w),
    .state_o (hash_o)
  );
endmodule

// File: rtl/rxh_unit_chk.sv
module rxh_unit_chk #(
  parameter int HASH_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              pair_vld_i,
  input logic              step_fire,
  input logic              word_end,
  input logic              sealed,
  input logic [HASH_W-1:0] mix_w,
  input logic [HASH_W-1:0] hash_o,
  input logic              done_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (hash_o == '0 && !done_o));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (hash_o == '0 && !done_o));

  // R3
  rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> $countones(hash_o) == $countones($past(mix_w)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pair_vld_i && !clr_i) |=> $stable(hash_o));

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
    word_end |=> done_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  sealed_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (sealed && !clr_i) |=> $stable(hash_o));

  // R8
  sealed_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    sealed |-> !step_fire);
endmodule

bind rxh_unit rxh_unit_chk #(.HASH_W(HASH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .pair_vld_i (pair_vld_i),
  .step_fire  (step_fire),
  .word_end   (word_end),
  .sealed     (sealed),
  .mix_w      (mix_w),
  .hash_o     (hash_o),
  .done_o     (done_o)
);

// File: tb/sim_rxh_unit.sv
module sim_rxh_unit;
  localparam logic [21:0] KEY0 = 22'h2A5C31;
  localparam logic [23:0] KEY1 = 24'h9E3779;

  typedef struct packed {
    logic [1:0]  n;
    logic        odd;
    logic [15:0] p0;
    logic [15:0] p1;
    logic [15:0] p2;
  } vec_t;

  // "the " / "cat" (odd) / "a" (odd) / "zebra" (odd) / "dogs" / "  " (spaces)
  localparam vec_t VEC [0:5] = '{
    '{2'd2, 1'b0, 16'h7468, 16'h6520, 16'h0000},
    '{2'd2, 1'b1, 16'h6361, 16'h74FF, 16'h0000},
    '{2'd1, 1'b1, 16'h6137, 16'h0000, 16'h0000},
    '{2'd3, 1'b1, 16'h7A65, 16'h6272, 16'h6100},
    '{2'd2, 1'b0, 16'h646F, 16'h6773, 16'h0000},
    '{2'd1, 1'b0, 16'h2020, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] pair = '0;
  logic        single = 1'b0;
  logic        last = 1'b0;
  logic [21:0] h0;
  logic [23:0] h1;
  logic        d0, d1;
  int          n_run = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  rxh_unit u0 (
    .clk(clk), .rst(rst), .clr_i(clr), .pair_vld_i(vld), .pair_i(pair),
    .single_i(single), .last_i(last), .hash_o(h0), .done_o(d0)
  );

  rxh_unit #(.HASH_W(24), .ROT(11), .HASH_KEY(KEY1)) u1 (
    .clk(clk), .rst(rst), .clr_i(clr), .pair_vld_i(vld), .pair_i(pair),
    .single_i(single), .last_i(last), .hash_o(h1), .done_o(d1)
  );

  // Reference step: XOR, then rotate left one position at a time.
  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [15:0] p,
                                           input logic [31:0] key, input int w, input int r);
    logic [31:0] mask, x;
    mask = (32'h1 << w) - 32'h1;
    x = (s ^ {16'h0, p} ^ key) & mask;
    for (int i = 0; i < r; i++) x = ((x << 1) | (x >> (w - 1))) & mask;
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge with inputs idle.
  task automatic tick(input logic c, input logic v, input logic [15:0] p,
                      input logic s, input logic l);
    clr = c; vld = v; pair = p; single = s; last = l;
    @(posedge clk);
    @(negedge clk);
    clr = 0; vld = 0; pair = '0; single = 0; last = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] e0, e1, held;
    logic [15:0] pv, pe;
    repeat (3) @(negedge clk);
    check("R1 hash during reset", {10'h0, h0}, 32'h0);
    check("R1 done during reset", {31'h0, d0}, 32'h0);
    rst = 0;
    @(negedge clk);
    check("R1 hash after reset", {10'h0, h0}, 32'h0);

    // R4: literal wrap check
    tick(1, 0, 16'h0, 0, 0);
    tick(0, 1, 16'h0000, 0, 0);
    check("R4 rotate wrap", {10'h0, h0}, 32'h002E18D4);

    // Table walk: R3, R6, R7, R9
    for (int v = 0; v < 6; v++) begin
      e0 = 0; e1 = 0;
      tick(1, 0, 16'h0, 0, 0);
      check("R2 clear zero", {10'h0, h0}, 32'h0);
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        pv = (k == 0) ? VEC[v].p0 : (k == 1) ? VEC[v].p1 : VEC[v].p2;
        pe = pv;
        if (VEC[v].odd && k == int'(VEC[v].n) - 1) pe = {pv[15:8], 8'h20};
        e0 = ref_step(e0, pe, {10'h0, KEY0}, 22, 7);
        e1 = ref_step(e1, pe, {8'h0, KEY1}, 24, 11);
        tick(0, 1, pv, VEC[v].odd && k == int'(VEC[v].n) - 1, k == int'(VEC[v].n) - 1);
        if (k < int'(VEC[v].n) - 1) check("R7 no done mid word", {31'h0, d0}, 32'h0);
      end
      check(VEC[v].odd ? "R6 padded hash" : "R3 word hash", {10'h0, h0}, e0);
      check("R9 second unit hash", {8'h0, h1}, e1);
      check("R7 done pulse", {31'h0, d0}, 32'h1);
      tick(0, 0, 16'h0, 0, 0);
      check("R7 done drops", {31'h0, d0}, 32'h0);
      check("R8 hash held", {10'h0, h0}, e0);
    end

    // R8: steps after end of word are ignored
    held = {10'h0, h0};
    tick(0, 1, 16'h4142, 0, 0);
    check("R8 step ignored", {10'h0, h0}, held);
    tick(0, 1, 16'h4344, 0, 1);
    check("R8 no second done", {31'h0, d0}, 32'h0);

    // R5: idle gaps hold the state
    tick(1, 0, 16'h0, 0, 0);
    tick(0, 1, 16'h6869, 0, 0);
    e0 = ref_step(0, 16'h6869, {10'h0, KEY0}, 22, 7);
    tick(0, 0, 16'h0, 0, 0);
    tick(0, 0, 16'hFFFF, 0, 1);
    check("R5 idle hold", {10'h0, h0}, e0);
    check("R5 no done on idle", {31'h0, d0}, 32'h0);

    // R2: clear with a step in the same cycle
    tick(1, 1, 16'h5555, 0, 1);
    check("R2 clear beats step", {10'h0, h0}, 32'h0);
    check("R2 clear beats last", {31'h0, d0}, 32'h0);

    // R10: reset mid word, then a fresh word starts from zero
    tick(0, 1, 16'h7071, 0, 0);
    rst = 1;
    tick(0, 1, 16'h7273, 0, 1);
    rst = 0;
    check("R10 reset drops hash", {10'h0, h0}, 32'h0);
    check("R10 reset drops done", {31'h0, d0}, 32'h0);
    tick(0, 1, 16'h7468, 0, 1);
    check("R10 fresh word", {10'h0, h0}, ref_step(0, 16'h7468, {10'h0, KEY0}, 22, 7));

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule